// File: doc/BRIEF.md
# Interrupt Pending and Forwarding Controller

This block gathers interrupt requests for one end of a serial chip-to-chip link and decides where they go. Requests land in a pending register. Three sources can set its bits: software writing to the register, an interrupt vector received from the far end of the link, and a local bus error. The bus error always sets one fixed bit.

A routing bit in the control register picks the destination of the pending bits. In remote routing, the block snapshots the pending vector and offers it to the serial transmitter through a valid/ready handshake. Once the transmitter reports that the packet is out, it clears exactly the bits it sent. In local routing, the pending bits move into a status register, which software clears by writing ones. Any non-zero status raises a single-cycle interrupt pulse. A further pulse follows every status write that leaves bits standing.

A soft-reset bit stops all forwarding and empties the status register while it is set. It also turns off the link-enable output. The pending and control registers keep their contents during soft reset. Hardware reset returns everything to zero.

Top module: `irq_fwd_ctrl`

## Requirements
- R1: After hardware reset (rst_n low at a clock edge), the control, pending and status registers read 0, and tx_valid, irq_pulse and link_en are 0.
- R2: A write to the pending register (address 1) sets every bit that is 1 in the write data. Bits written 0 keep their value. A read of address 1 returns the current pending vector.
- R3: A cycle with rx_irq_valid high ORs rx_irq_vec into the pending register. A cycle with bus_err high sets pending bit ERR_BIT, which is bit 31 by default.
- R4: With the routing bit (control bit 1) at 0, the block waits for an idle transmitter and a non-zero pending register. One cycle later, tx_valid rises with tx_vec equal to the pending vector at that moment. tx_valid and tx_vec stay constant until a cycle with tx_ready high.
- R5: A tx_done pulse after acceptance clears only the bits of the sent snapshot from the pending register. Bits that arrived during the packet remain and start a further packet.
- R6: With the routing bit at 1 and the transmitter idle, non-zero pending bits move into the status register one cycle later and leave the pending register.
- R7: A write to the status register (address 2) clears every bit that is 1 in the write data. Bits written 0 keep their value. A read of address 2 returns the status vector.
- R8: irq_pulse is high for exactly one cycle in the cycle where the status register goes from all-zero to non-zero.
- R9: A status write that leaves the status register non-zero makes irq_pulse high in the next cycle. A status write that leaves it zero gives no pulse.
- R10: While the soft-reset bit (control bit 0) is 1, the following holds. The status register is 0, tx_valid and irq_pulse stay low, and rx_irq_valid and bus_err are ignored. The pending and control registers keep their values, software writes still reach them, and forwarding resumes after the bit is cleared.
- R11: link_en equals the link-enable bit (control bit 2) AND NOT the soft-reset bit. The control register (address 0) is written as a whole and reads back its 3 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 pending, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| rx_irq_valid | input | 1 | Received interrupt vector is valid this cycle |
| rx_irq_vec | input | 32 | Received interrupt vector |
| bus_err | input | 1 | Serial bus error event |
| tx_valid | output | 1 | Outgoing interrupt packet offered |
| tx_ready | input | 1 | Transmitter accepts the packet |
| tx_vec | output | 32 | Outgoing interrupt vector |
| tx_done | input | 1 | Transmission of the accepted packet has completed |
| link_en | output | 1 | Serial interface enable |
| irq_pulse | output | 1 | Single-cycle local interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit vector and the error bit at position 31. This makes the top bit reachable, so the bench can tell an error-set bit apart from a received one. The 32-bit width also lets a packet snapshot differ from bits added while the packet is in flight. Running at full width covers two further cases: clear-on-done leaving late arrivals behind, and status write-one-to-clear with both pulse and no-pulse outcomes.

// File: rtl/irq_fwd_pkg.sv
// Package: shared register addresses and control bit positions for the
// interrupt forwarding controller. Assumes a 2-bit register address.
package irq_fwd_pkg;
    localparam int ADDR_W = 2;
    localparam int CTRL_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 2'd0,
        RA_PEND = 2'd1,
        RA_STAT = 2'd2
    } reg_addr_e;

    // control register bit positions
    localparam int CB_SOFT_RST = 0;
    localparam int CB_ROUTE_LOC = 1;
    localparam int CB_LINK_ON = 2;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_OFFER = 2'd1,
        TX_FLIGHT = 2'd2
    } tx_state_e;
endpackage

// File: rtl/irq_pend_reg.sv
// Pending register: holds the interrupt requests that are not yet forwarded.
// Assumes the set and clear masks are already qualified by the caller.
// When a bit is set and cleared in the same cycle, the set wins, so no
// request is lost.
module irq_pend_reg #(
    parameter int VEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] set_mask,
    input  logic [VEC_W-1:0] clr_mask,
    output logic [VEC_W-1:0] pend
);
    // update pending bits: drop cleared bits, then add newly set bits
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_mask) | set_mask;
    end
endmodule

// File: rtl/irq_tx_fsm.sv
// Packet sequencer for remote routing. It snapshots the pending vector,
// offers it on a valid/ready handshake and, on the completion strobe,
// returns the snapshot as a clear mask. Assumes tx_done only counts after
// the transmitter has accepted the packet. A soft reset drops the packet
// and returns the sequencer to idle.
module irq_tx_fsm
    import irq_fwd_pkg::*;
#(
    parameter int VEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             remote_en,
    input  logic [VEC_W-1:0] pend,
    input  logic             tx_ready,
    input  logic             tx_done,
    output logic             tx_valid,
    output logic [VEC_W-1:0] tx_vec,
    output logic [VEC_W-1:0] sent_clr,
    output logic             idle
);
    tx_state_e        state;
    logic [VEC_W-1:0] snap;

    // sequencer state and snapshot register
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state <= TX_IDLE;
            snap  <= '0;
        end else begin
            unique case (state)
                TX_IDLE: if (remote_en && (pend != '0)) begin
                    snap  <= pend;
                    state <= TX_OFFER;
                end
                TX_OFFER: if (tx_ready) state <= TX_FLIGHT;
                TX_FLIGHT: if (tx_done) begin
                    snap  <= '0;
                    state <= TX_IDLE;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // handshake outputs and the clear mask released on completion
    always_comb begin
        tx_valid = (state == TX_OFFER);
        tx_vec   = snap;
        idle     = (state == TX_IDLE);
        sent_clr = (state == TX_FLIGHT && tx_done) ? snap : '0;
    end
endmodule

// File: rtl/irq_stat_pulse.sv
// Local status register with write-one-to-clear and the interrupt pulse.
// Assumes move_bits has already been removed from the pending register.
// The pulse is registered and lines up with the status value it reports.
module irq_stat_pulse #(
    parameter int VEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [VEC_W-1:0] move_bits,
    input  logic             clr_wr,
    input  logic [VEC_W-1:0] clr_data,
    output logic [VEC_W-1:0] stat,
    output logic             irq_pulse
);
    logic [VEC_W-1:0] stat_nx;
    logic             rise;
    logic             rearm;

    // next status value and the two pulse causes
    always_comb begin
        stat_nx = (stat & ~(clr_wr ? clr_data : '0)) | move_bits;
        rise    = (stat == '0) && (stat_nx != '0);
        rearm   = clr_wr && (stat_nx != '0);
    end

    // status register and registered single-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            stat      <= '0;
            irq_pulse <= 1'b0;
        end else begin
            stat      <= stat_nx;
            irq_pulse <= rise || rearm;
        end
    end
endmodule

// File: rtl/irq_fwd_ctrl.sv
// Top of the interrupt forwarding controller. It decodes the register port,
// qualifies the request sources and steers the pending bits either to the
// packet sequencer or into the local status register. Assumes a single-cycle
// register write strobe and a combinational read path.
module irq_fwd_ctrl
    import irq_fwd_pkg::*;
#(
    parameter int VEC_W   = 32,
    parameter int ERR_BIT = VEC_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [VEC_W-1:0]  reg_wdata,
    output logic [VEC_W-1:0]  reg_rdata,
    input  logic              rx_irq_valid,
    input  logic [VEC_W-1:0]  rx_irq_vec,
    input  logic              bus_err,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [VEC_W-1:0]  tx_vec,
    input  logic              tx_done,
    output logic              link_en,
    output logic              irq_pulse
);
    localparam logic [VEC_W-1:0] ERR_MASK = VEC_W'(1) << ERR_BIT;

    logic [CTRL_W-1:0] ctrl_q;
    logic [VEC_W-1:0]  pend_q;
    logic [VEC_W-1:0]  stat_q;
    logic [VEC_W-1:0]  set_mask;
    logic [VEC_W-1:0]  clr_mask;
    logic [VEC_W-1:0]  sent_clr;
    logic [VEC_W-1:0]  move_bits;
    logic              soft_rst;
    logic              route_local;
    logic              tx_idle;
    logic              wr_ctrl;
    logic              wr_pend;
    logic              wr_stat;

    // register write decode
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
        wr_pend = reg_wr && (reg_addr == RA_PEND);
        wr_stat = reg_wr && (reg_addr == RA_STAT);
    end

    // control register, replaced as a whole on write
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
    end

    // control fields and the link enable
    always_comb begin
        soft_rst    = ctrl_q[CB_SOFT_RST];
        route_local = ctrl_q[CB_ROUTE_LOC];
        link_en     = ctrl_q[CB_LINK_ON] && !soft_rst;
    end

    // pending sources; link-side events are dropped during soft reset
    always_comb begin
        set_mask = wr_pend ? reg_wdata : '0;
        if (!soft_rst && rx_irq_valid) set_mask = set_mask | rx_irq_vec;
        if (!soft_rst && bus_err)      set_mask = set_mask | ERR_MASK;
    end

    // local move when the sequencer is idle, plus clear on completion
    always_comb begin
        move_bits = (route_local && !soft_rst && tx_idle) ? pend_q : '0;
        clr_mask  = sent_clr | move_bits;
    end

    irq_pend_reg #(.VEC_W(VEC_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .pend     (pend_q)
    );

    irq_tx_fsm #(.VEC_W(VEC_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .remote_en (!route_local),
        .pend      (pend_q),
        .tx_ready  (tx_ready),
        .tx_done   (tx_done),
        .tx_valid  (tx_valid),
        .tx_vec    (tx_vec),
        .sent_clr  (sent_clr),
        .idle      (tx_idle)
    );

    irq_stat_pulse #(.VEC_W(VEC_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .move_bits (move_bits),
        .clr_wr    (wr_stat),
        .clr_data  (reg_wdata),
        .stat      (stat_q),
        .irq_pulse (irq_pulse)
    );

    // register read mux
    always_comb begin
        unique case (reg_addr)
            RA_CTRL: reg_rdata = VEC_W'(ctrl_q);
            RA_PEND: reg_rdata = pend_q;
            RA_STAT: reg_rdata = stat_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_fwd_chk.sv
// Checker for the interrupt forwarding controller, bound to every instance.
module irq_fwd_chk #(
    parameter int VEC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       ctrl_q,
    input logic [VEC_W-1:0] stat_q,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [VEC_W-1:0] tx_vec,
    input logic             irq_pulse,
    input logic             link_en
);
    // R4
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !ctrl_q[0]) |=> (tx_valid && $stable(tx_vec)));

    // R8
    rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_q) == '0 && stat_q != '0) |-> irq_pulse);

    // R8
    pulse_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (stat_q != '0));

    // R10
    srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[0] |=> (stat_q == '0 && !tx_valid && !irq_pulse));

    // R11
    link_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[0] |-> !link_en);
endmodule

bind irq_fwd_ctrl irq_fwd_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_q    (ctrl_q),
    .stat_q    (stat_q),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_vec    (tx_vec),
    .irq_pulse (irq_pulse),
    .link_en   (link_en)
);

// File: tb/tb_irq_fwd_ctrl.sv
`timescale 1ns/1ps
module tb_irq_fwd_ctrl;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  reg_rdata;
    logic          rx_irq_valid = 1'b0;
    logic [W-1:0]  rx_irq_vec = '0;
    logic          bus_err = 1'b0;
    logic          tx_valid;
    logic          tx_ready = 1'b0;
    logic [W-1:0]  tx_vec;
    logic          tx_done = 1'b0;
    logic          link_en;
    logic          irq_pulse;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;
    bit   mon_on = 0;
    logic prev_v = 1'b0;
    logic [W-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    irq_fwd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_irq_valid(rx_irq_valid), .rx_irq_vec(rx_irq_vec), .bus_err(bus_err),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_vec(tx_vec),
        .tx_done(tx_done), .link_en(link_en), .irq_pulse(irq_pulse)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [W-1:0] exp,
                          input string req);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic pulse_done();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    // monitor: every new packet offer is compared with the scoreboard head
    always @(negedge clk) begin
        if (mon_on && tx_valid && !prev_v) begin
            if (exp_q.size() == 0) chk(1'b0, "R4 unexpected packet", tx_vec, '0);
            else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                chk(tx_vec == e, "R4 packet vector", tx_vec, e);
            end
        end
        prev_v <= tx_valid;
    end

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(0, 0, "R1 ctrl");
        rd_chk(1, 0, "R1 pend");
        rd_chk(2, 0, "R1 stat");
        chk(!tx_valid && !irq_pulse && !link_en, "R1 outputs",
            {tx_valid, irq_pulse, link_en}, 0);
        mon_on = 1;

        // remote routing, link on
        wr(0, 32'h4);
        chk(link_en == 1'b1, "R11 link_en on", link_en, 1);
        rd_chk(0, 32'h4, "R11 ctrl readback");
        exp_q.push_back(32'hA5);
        wr(1, 32'hA5);
        rd_chk(1, 32'hA5, "R2 pending set");
        @(negedge clk);
        chk(tx_valid && tx_vec == 32'hA5, "R4 offer", tx_vec, 32'hA5);
        repeat (3) @(negedge clk);
        chk(tx_valid && tx_vec == 32'hA5, "R4 hold without ready", tx_vec, 32'hA5);
        wr(1, 32'h0);
        rd_chk(1, 32'hA5, "R2 write zero no effect");
        rx_irq_valid = 1'b1; rx_irq_vec = 32'h100;
        @(negedge clk);
        rx_irq_valid = 1'b0; rx_irq_vec = '0;
        rd_chk(1, 32'h1A5, "R3 remote vector");
        tx_ready = 1'b1;
        @(negedge clk);
        chk(!tx_valid, "R4 accepted", tx_valid, 0);
        exp_q.push_back(32'h100);
        pulse_done();
        rd_chk(1, 32'h100, "R5 only snapshot cleared");
        repeat (2) @(negedge clk);
        pulse_done();
        rd_chk(1, 32'h0, "R5 second packet cleared");

        // error bit
        exp_q.push_back(32'h8000_0000);
        @(negedge clk); bus_err = 1'b1;
        @(negedge clk); bus_err = 1'b0;
        rd_chk(1, 32'h8000_0000, "R3 error bit 31");
        repeat (2) @(negedge clk);
        pulse_done();
        rd_chk(1, 32'h0, "R5 error packet cleared");

        // local routing
        wr(0, 32'h6);
        wr(1, 32'h3);
        @(negedge clk);
        rd_chk(1, 32'h0, "R6 pending emptied");
        rd_chk(2, 32'h3, "R6 moved to status");
        chk(irq_pulse, "R8 pulse on rise", irq_pulse, 1);
        @(negedge clk);
        chk(!irq_pulse, "R8 single cycle", irq_pulse, 0);
        wr(2, 32'h1);
        rd_chk(2, 32'h2, "R7 write one clears");
        chk(irq_pulse, "R9 repulse on write", irq_pulse, 1);
        @(negedge clk);
        chk(!irq_pulse, "R9 repulse single", irq_pulse, 0);
        wr(2, 32'h0);
        rd_chk(2, 32'h2, "R7 write zero no effect");
        chk(irq_pulse, "R9 repulse on zero write", irq_pulse, 1);
        wr(2, 32'h2);
        rd_chk(2, 32'h0, "R7 cleared all");
        chk(!irq_pulse, "R9 no pulse when empty", irq_pulse, 0);
        @(negedge clk); rx_irq_valid = 1'b1; rx_irq_vec = 32'h10;
        @(negedge clk); rx_irq_valid = 1'b0; rx_irq_vec = '0;
        @(negedge clk);
        rd_chk(2, 32'h10, "R6 remote vector to status");
        chk(irq_pulse, "R8 pulse from remote", irq_pulse, 1);
        wr(2, 32'h10);

        // soft reset in local routing
        wr(1, 32'h40);
        @(negedge clk);
        rd_chk(2, 32'h40, "R6 status before soft reset");
        wr(0, 32'h7);
        @(negedge clk);
        rd_chk(2, 32'h0, "R10 status cleared");
        rd_chk(0, 32'h7, "R10 ctrl retained");
        chk(!link_en, "R11 link off in soft reset", link_en, 0);
        wr(1, 32'h8);
        repeat (3) @(negedge clk);
        rd_chk(1, 32'h8, "R10 pending held");
        rd_chk(2, 32'h0, "R10 no move");
        @(negedge clk); bus_err = 1'b1;
        @(negedge clk); bus_err = 1'b0;
        rd_chk(1, 32'h8, "R10 error ignored");
        wr(0, 32'h6);
        @(negedge clk);
        rd_chk(2, 32'h8, "R10 resume move");
        chk(irq_pulse && link_en, "R10 resume pulse and link", {irq_pulse, link_en}, 2'b11);
        wr(2, 32'h8);

        // soft reset in remote routing
        wr(0, 32'h5);
        wr(1, 32'h2);
        repeat (3) @(negedge clk);
        chk(!tx_valid, "R10 no packet in soft reset", tx_valid, 0);
        exp_q.push_back(32'h2);
        wr(0, 32'h4);
        repeat (3) @(negedge clk);
        pulse_done();
        rd_chk(1, 32'h0, "R10 resumed packet cleared");
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all packets seen", exp_q.size(), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule